// File: doc/BRIEF.md
# Mixed-Sign Multiplier Pair with First-Stage Adder

This block is one half-slice of an arithmetic unit. Two multiplier lanes take an A operand and a B operand each and form full-precision products. One A sign control and one B sign control apply to both lanes, and each can change on every transaction. A fixed-function adder behind the multipliers then combines the two products. Whether that adder adds or subtracts is set by an elaboration parameter, not by a port. The adder takes only the two products as its inputs.

The requested operand width is rounded up to the next native multiplier width: 9, 12, 18 or 36 bits. Each operand is widened by one more bit, filled with its sign bit when it is signed and with zero when it is unsigned. One signed core of width native+1 therefore serves all four sign combinations. A second parameter selects what appears at the output. In sum mode the output carries the combined result. In split mode it carries both products side by side. Inputs and result are each registered once, and a valid flag travels with the data.

Top module: `mixsign_mul_pair`

## Requirements
- R1: `sign_a_i`=1 makes both A operands two's-complement signed and `sign_b_i`=1 makes both B operands signed. A value of 0 makes the matching operands unsigned, so with both controls low the products are unsigned.
- R2: `NAT_W` is REQ_W rounded up to 9, 12, 18 or 36. Operands are extended from bit REQ_W-1, by sign when signed and by zero otherwise. Each product field is PROD_W = 2*NAT_W+2 bits wide, and `result_o` is 2*PROD_W bits wide.
- R3: With SPLIT_EN=0, `result_o` is p0+p1, or p0-p1 when SUB_EN=1, sign-extended to the full width. p0 = a0*b0 and p1 = a1*b1. The result never wraps.
- R4: With SPLIT_EN=1, `result_o[PROD_W-1:0]` holds p0 and `result_o[2*PROD_W-1:PROD_W]` holds p1. Each product is exact and sign-extended for every sign combination.
- R5: `valid_o` equals `valid_i` from two rising edges earlier, and the matching result appears on `result_o` in the same cycle.
- R6: Operands and sign controls are ignored in cycles where `valid_i`=0. `result_o` does not change in any cycle where `valid_o` is low.
- R7: An active-low asynchronous reset forces `valid_o` and `result_o` to zero.
- R8: With both sign controls 0 and SUB_EN=0, every result field is non-negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Transaction strobe for operands and sign controls |
| sign_a_i | input | 1 | 1: A operands signed, 0: unsigned |
| sign_b_i | input | 1 | 1: B operands signed, 0: unsigned |
| a0_i | input | REQ_W | A operand, lane 0 |
| a1_i | input | REQ_W | A operand, lane 1 |
| b0_i | input | REQ_W | B operand, lane 0 |
| b1_i | input | REQ_W | B operand, lane 1 |
| valid_o | output | 1 | Result strobe |
| result_o | output | 2*PROD_W | Combined result or product pair |

## Verification
The assertions check the following on every cycle:
- the two-cycle alignment of `valid_o` with `valid_i`;
- that the output holds while `valid_o` is low;
- the cleared state during reset;
- that an all-unsigned transaction never yields a negative field.

Only the bench's scenarios can show that the arithmetic is exact. These scenarios cover extreme operands under each sign pairing, the rounding of the requested width, the subtract variant at a second native width, and the split layout. The bench also shows that operands changed while `valid_i` is low never reach the output.

// File: rtl/mixsign_pkg.sv
package mixsign_pkg;

  // round a requested operand width up to the next native multiplier width
  function automatic int native_w(input int req_w);
    if (req_w <= 9)       return 9;
    else if (req_w <= 12) return 12;
    else if (req_w <= 18) return 18;
    else                  return 36;
  endfunction

  typedef enum logic [0:0] {
    ADD_PRODUCTS = 1'b0,
    SUB_PRODUCTS = 1'b1
  } adder_op_e;

endpackage

// File: rtl/mixsign_operand_ext.sv
module mixsign_operand_ext #(
  parameter int IN_W  = 16,
  parameter int EXT_W = 19
) (
  input  logic [IN_W-1:0]         data_i,
  input  logic                    signed_i,
  output logic signed [EXT_W-1:0] data_o
);
  logic fill;
  assign fill   = signed_i & data_i[IN_W-1];
  assign data_o = {{(EXT_W-IN_W){fill}}, data_i};
endmodule

// File: rtl/mixsign_mul_core.sv
module mixsign_mul_core #(
  parameter int W = 19
) (
  input  logic signed [W-1:0]   a_i,
  input  logic signed [W-1:0]   b_i,
  output logic signed [2*W-1:0] p_o
);
  logic signed [2*W-1:0] a_x, b_x;
  assign a_x = {{W{a_i[W-1]}}, a_i};
  assign b_x = {{W{b_i[W-1]}}, b_i};
  assign p_o = a_x * b_x;
endmodule

// File: rtl/mixsign_first_adder.sv
module mixsign_first_adder #(
  parameter int PW = 38,
  parameter mixsign_pkg::adder_op_e OP = mixsign_pkg::ADD_PRODUCTS
) (
  input  logic signed [PW-1:0] p0_i,
  input  logic signed [PW-1:0] p1_i,
  output logic signed [PW-1:0] sum_o
);
  // products fit in PW-1 signed bits, so PW bits hold sum or difference
  generate
    if (OP == mixsign_pkg::SUB_PRODUCTS) begin : g_sub
      assign sum_o = p0_i - p1_i;
    end else begin : g_add
      assign sum_o = p0_i + p1_i;
    end
  endgenerate
endmodule

// File: rtl/mixsign_mul_pair.sv
module mixsign_mul_pair
  import mixsign_pkg::*;
#(
  parameter int REQ_W    = 16,
  parameter bit SUB_EN   = 1'b0,
  parameter bit SPLIT_EN = 1'b0,
  localparam int NAT_W   = native_w(REQ_W),
  localparam int XW      = NAT_W + 1,
  localparam int PROD_W  = 2 * XW,
  localparam int RES_W   = 2 * PROD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sign_a_i,
  input  logic             sign_b_i,
  input  logic [REQ_W-1:0] a0_i,
  input  logic [REQ_W-1:0] a1_i,
  input  logic [REQ_W-1:0] b0_i,
  input  logic [REQ_W-1:0] b1_i,
  output logic             valid_o,
  output logic [RES_W-1:0] result_o
);
  localparam int LANES = 2;
  localparam adder_op_e OP = SUB_EN ? SUB_PRODUCTS : ADD_PRODUCTS;

  // input stage
  logic                        v1_q, sa_q, sb_q;
  logic [LANES-1:0][REQ_W-1:0] a_q, b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      sa_q <= 1'b0;
      sb_q <= 1'b0;
      a_q  <= '0;
      b_q  <= '0;
    end else begin
      v1_q <= valid_i;
      if (valid_i) begin
        sa_q <= sign_a_i;
        sb_q <= sign_b_i;
        a_q  <= {a1_i, a0_i};
        b_q  <= {b1_i, b0_i};
      end
    end
  end

  // multiplier lanes share one sign-control pair
  logic signed [PROD_W-1:0] prod [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [XW-1:0] a_x, b_x;

    mixsign_operand_ext #(.IN_W(REQ_W), .EXT_W(XW)) u_ext_a (
      .data_i(a_q[g]), .signed_i(sa_q), .data_o(a_x)
    );
    mixsign_operand_ext #(.IN_W(REQ_W), .EXT_W(XW)) u_ext_b (
      .data_i(b_q[g]), .signed_i(sb_q), .data_o(b_x)
    );
    mixsign_mul_core #(.W(XW)) u_mul (
      .a_i(a_x), .b_i(b_x), .p_o(prod[g])
    );
  end

  // output select
  logic [RES_W-1:0] res_d;

  generate
    if (SPLIT_EN) begin : g_split
      assign res_d = {prod[1], prod[0]};
    end else begin : g_sum
      logic signed [PROD_W-1:0] sum;
      mixsign_first_adder #(.PW(PROD_W), .OP(OP)) u_add (
        .p0_i(prod[0]), .p1_i(prod[1]), .sum_o(sum)
      );
      assign res_d = {{PROD_W{sum[PROD_W-1]}}, sum};
    end
  endgenerate

  // output stage
  logic             vo_q;
  logic [RES_W-1:0] res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vo_q  <= 1'b0;
      res_q <= '0;
    end else begin
      vo_q <= v1_q;
      if (v1_q) res_q <= res_d;
    end
  end

  assign valid_o  = vo_q;
  assign result_o = res_q;

endmodule

// File: rtl/mixsign_mul_pair_chk.sv
module mixsign_mul_pair_chk
  import mixsign_pkg::*;
#(
  parameter int REQ_W    = 16,
  parameter bit SUB_EN   = 1'b0,
  parameter bit SPLIT_EN = 1'b0,
  localparam int PROD_W  = 2 * (native_w(REQ_W) + 1),
  localparam int RES_W   = 2 * PROD_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             sign_a_i,
  input logic             sign_b_i,
  input logic             valid_o,
  input logic [RES_W-1:0] result_o
);
  logic [1:0] cyc;
  logic       rst_seen = 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cyc <= 2'd0;
    else if (cyc != 2'd2)  cyc <= cyc + 2'd1;
  end

  always_ff @(posedge clk_i) rst_seen <= !rst_ni;

  always @(posedge clk_i) begin
    if (!rst_ni && rst_seen) begin
      assert_reset_clear_R7: assert (!valid_o && result_o == '0)
        else $error("R7: outputs not cleared in reset");
    end
  end

  assert_valid_latency_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 2'd2) |-> (valid_o == $past(valid_i, 2)))
    else $error("R5: valid_o misaligned");

  assert_hold_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc != 2'd0 && !valid_o) |-> $stable(result_o))
    else $error("R6: result changed without valid");

  generate
    if (!SUB_EN) begin : g_unsigned
      assert_unsigned_nonneg_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc == 2'd2 && valid_o && !$past(sign_a_i, 2) && !$past(sign_b_i, 2))
          |-> (!result_o[RES_W-1] && !result_o[PROD_W-1]))
        else $error("R8: negative field from unsigned operands");
    end
  endgenerate

endmodule

bind mixsign_mul_pair mixsign_mul_pair_chk #(
  .REQ_W(REQ_W), .SUB_EN(SUB_EN), .SPLIT_EN(SPLIT_EN)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
  .sign_a_i(sign_a_i), .sign_b_i(sign_b_i),
  .valid_o(valid_o), .result_o(result_o)
);

// File: tb/sim_mixsign_mul_pair.sv
`timescale 1ns/1ps
module sim_mixsign_mul_pair;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        vin = 1'b0, sa = 1'b0, sb = 1'b0;
  logic [15:0] a0 = '0, a1 = '0, b0 = '0, b1 = '0;
  logic        vo0, vo1, vo2;
  logic [75:0] r0, r1;
  logic [51:0] r2;

  int checks = 0, errors = 0;
  bit done = 1'b0, sb_en = 1'b0;

  // u0: sum/add 16b->18, u1: split 16b->18, u2: sum/sub 12b native
  mixsign_mul_pair #(.REQ_W(16), .SUB_EN(1'b0), .SPLIT_EN(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .sign_a_i(sa), .sign_b_i(sb),
    .a0_i(a0), .a1_i(a1), .b0_i(b0), .b1_i(b1), .valid_o(vo0), .result_o(r0));
  mixsign_mul_pair #(.REQ_W(16), .SUB_EN(1'b0), .SPLIT_EN(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .sign_a_i(sa), .sign_b_i(sb),
    .a0_i(a0), .a1_i(a1), .b0_i(b0), .b1_i(b1), .valid_o(vo1), .result_o(r1));
  mixsign_mul_pair #(.REQ_W(12), .SUB_EN(1'b1), .SPLIT_EN(1'b0)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .sign_a_i(sa), .sign_b_i(sb),
    .a0_i(a0[11:0]), .a1_i(a1[11:0]), .b0_i(b0[11:0]), .b1_i(b1[11:0]),
    .valid_o(vo2), .result_o(r2));

  task automatic chk(input bit ok, input string req, input logic [75:0] act, input logic [75:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic longint opv(input logic [15:0] x, input int w, input bit s);
    longint r;
    r = longint'(x) & ((longint'(1) << w) - 1);
    if (s && x[w-1]) r = r - (longint'(1) << w);
    return r;
  endfunction

  function automatic logic [75:0] exp_sum(input logic [15:0] x0, x1, y0, y1,
                                          input bit s_a, s_b, input int w, input bit sub);
    longint p0, p1, s;
    logic signed [75:0] e;
    p0 = opv(x0, w, s_a) * opv(y0, w, s_b);
    p1 = opv(x1, w, s_a) * opv(y1, w, s_b);
    s  = sub ? p0 - p1 : p0 + p1;
    e  = 76'(s);
    return e;
  endfunction

  function automatic logic [75:0] exp_split(input logic [15:0] x0, x1, y0, y1,
                                            input bit s_a, s_b);
    longint p0, p1;
    logic signed [37:0] q0, q1;
    p0 = opv(x0, 16, s_a) * opv(y0, 16, s_b);
    p1 = opv(x1, 16, s_a) * opv(y1, 16, s_b);
    q0 = 38'(p0);
    q1 = 38'(p1);
    return {q1, q0};
  endfunction

  // reference pipeline built from the requirements
  logic        m1_v = 1'b0, m1_sa = 1'b0, m1_sb = 1'b0;
  logic [15:0] m1_a0 = '0, m1_a1 = '0, m1_b0 = '0, m1_b1 = '0;
  logic        mo_v = 1'b0, mo_uns = 1'b0;
  logic [75:0] e0 = '0, e1 = '0, e2 = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1_v <= 1'b0; mo_v <= 1'b0; e0 <= '0; e1 <= '0; e2 <= '0;
      m1_sa <= 1'b0; m1_sb <= 1'b0; mo_uns <= 1'b0;
    end else begin
      m1_v <= vin;
      if (vin) begin
        m1_sa <= sa; m1_sb <= sb; m1_a0 <= a0; m1_a1 <= a1; m1_b0 <= b0; m1_b1 <= b1;
      end
      mo_v <= m1_v;
      if (m1_v) begin
        e0 <= exp_sum(m1_a0, m1_a1, m1_b0, m1_b1, m1_sa, m1_sb, 16, 1'b0);
        e1 <= exp_split(m1_a0, m1_a1, m1_b0, m1_b1, m1_sa, m1_sb);
        e2 <= {24'b0, exp_sum(m1_a0, m1_a1, m1_b0, m1_b1, m1_sa, m1_sb, 12, 1'b1)[51:0]};
        mo_uns <= !m1_sa && !m1_sb;
      end
    end
  end

  always @(negedge clk) begin
    if (sb_en && rst_n) begin
      chk(vo0 == mo_v && vo1 == mo_v && vo2 == mo_v, "R5", {73'b0, vo0, vo1, vo2}, {73'b0, mo_v, mo_v, mo_v});
      chk(r0 == e0, !mo_v ? "R6" : (mo_uns ? "R8" : "R3"), r0, e0);
      chk(r1 == e1, !mo_v ? "R6" : (mo_uns ? "R8" : "R4"), r1, e1);
      chk({24'b0, r2} == e2, !mo_v ? "R6" : "R3", {24'b0, r2}, e2);
    end
  end

  task automatic drive(input bit v, input bit s_a, s_b, input logic [15:0] x0, x1, y0, y1);
    @(negedge clk);
    vin = v; sa = s_a; sb = s_b; a0 = x0; a1 = x1; b0 = y0; b1 = y1;
  endtask

  function automatic logic [15:0] pick();
    case ($urandom % 8)
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'hFFFF;
      3: return 16'h0000;
      4: return 16'h0800;
      5: return 16'h07FF;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(vo0 == 1'b0 && r0 == '0 && r1 == '0 && r2 == '0, "R7", r0, '0);
    rst_n = 1'b1;
    sb_en = 1'b1;

    // R1: both signed, extremes
    drive(1, 1, 1, 16'h8000, 16'hFFFF, 16'h8000, 16'h0002);
    drive(0, 0, 0, 16'h1234, 16'h1234, 16'h1234, 16'h1234);
    @(negedge clk);
    chk(r0 == 76'h3FFFFFFE, "R1", r0, 76'h3FFFFFFE);
    chk(r1 == {38'h3FFFFFFFFE, 38'h0040000000}, "R1", r1, {38'h3FFFFFFFFE, 38'h0040000000});

    // R8: same bits, both unsigned
    drive(1, 0, 0, 16'h8000, 16'hFFFF, 16'h8000, 16'h0002);
    drive(0, 1, 1, 16'hAAAA, 16'h5555, 16'hAAAA, 16'h5555);
    @(negedge clk);
    chk(r0 == 76'h4001FFFE, "R8", r0, 76'h4001FFFE);

    // R2: sign taken from bit REQ_W-1; 12-bit slice with subtract
    drive(1, 1, 0, 16'hFFFF, 16'h0001, 16'hFFFF, 16'h0001);
    drive(0, 0, 1, 16'h7777, 16'h7777, 16'h7777, 16'h7777);
    @(negedge clk);
    chk(r1 == {38'h0000000001, 38'h3FFFFF0001}, "R2", r1, {38'h0000000001, 38'h3FFFFF0001});
    chk(r2 == 52'hFFFFFFFFFF000, "R2", {24'b0, r2}, {24'b0, 52'hFFFFFFFFFF000});

    // R6: churn inputs with valid low, result must hold
    for (int i = 0; i < 6; i++) drive(0, i[0], i[1], 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
    @(negedge clk);
    chk(r2 == 52'hFFFFFFFFFF000 && vo2 == 1'b0, "R6", {24'b0, r2}, {24'b0, 52'hFFFFFFFFFF000});

    // back-to-back and random traffic
    for (int i = 0; i < 3000; i++)
      drive(($urandom % 10) < 7, $urandom % 2, $urandom % 2, pick(), pick(), pick(), pick());
    drive(0, 0, 0, 16'h0, 16'h0, 16'h0, 16'h0);

    // R7: asynchronous reset mid-stream
    drive(1, 1, 1, 16'h8000, 16'h8000, 16'h8000, 16'h8000);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(vo0 == 1'b0 && vo1 == 1'b0 && r0 == '0 && r1 == '0 && r2 == '0, "R7", r1, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) drive(1, 0, 1, pick(), pick(), pick(), pick());
    drive(0, 0, 0, 16'h0, 16'h0, 16'h0, 16'h0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule